// File: doc/BRIEF.md
# Programmable Loop Divider with Prescaler Select

This block is the feedback divider of a frequency synthesizer. It takes two local-oscillator inputs, each modelled as a single-cycle tick on a fast system clock. A select input chooses which one is divided. The AM tick stream goes through a fixed divide-by-8 prescaler. The FM tick stream goes through a dual-modulus prescaler that divides by 64 or by 63. A 14-bit down-counter then divides the prescaled pulses by N+1. The output is one pulse per completed division cycle, and it feeds a phase comparator.

On the FM path, the low six bits of the code set a swallow count A. During each division cycle, the first A prescaled pulses use the divide-by-64 modulus and the remaining pulses use divide-by-63. A new code is taken only at the terminal count, so a cycle already in progress always completes. Changing the select input clears the prescalers and the counter.

Top module: `loop_divider`

## Requirements
- R1: With `fm_sel` low, the output repeats every 8*(N+1) AM ticks, where N is `div_code`. The count is in ticks, not clock cycles.
- R2: With `fm_sel` high, the output repeats every 64*A + 63*(N+1-A) FM ticks, where A = `div_code[5:0]`.
- R3: A code of N=0 gives one output pulse per prescaled pulse: every 8 AM ticks, or every 63 FM ticks.
- R4: `fm_sel` high selects the FM input and low selects the AM input. Ticks on the input that is not selected have no effect on the output.
- R5: `div_code` is sampled only at the terminal count. A code change in the middle of a cycle leaves that cycle's length unchanged and applies from the next cycle.
- R6: A change of `fm_sel` clears the prescaler and the counter. The first output after the change comes after one prescaled pulse (8 or 63 ticks), and the full division applies from then on.
- R7: While reset is held, `div_pulse` is low. After reset the first output comes after one prescaled pulse.
- R8: `div_pulse` is high for one clock, in the clock after the tick that completes the division. It is never high in two consecutive clocks.
- R9: All 14 code bits take part in the division. A code with bit 13 set divides by its full value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| am_tick | input | 1 | One-cycle AM oscillator tick |
| fm_tick | input | 1 | One-cycle FM oscillator tick |
| fm_sel | input | 1 | 1 selects the FM path, 0 selects the AM path |
| div_code | input | 14 | Division code N; the block divides by N+1 |
| div_pulse | output | 1 | One-cycle pulse at the end of each division cycle |

## Verification
The bench checks the FM swallow arithmetic at several codes. A design that swapped the two moduli, or that swallowed from the wrong code bits, would come out off by one tick per prescaled pulse. It checks N=0 and a code with bit 13 set, which catch a divide-by-N error and a truncated counter. A code change in the middle of a cycle would expose a design that reloads at once. A select switch would expose a design that keeps a stale prescaler phase, because it would produce a short first period. A stretch of ticks on the unselected input, and a stretch of gapped ticks, would show any leakage between the paths or any counting of clocks instead of ticks.

// File: rtl/loopdiv_pkg.sv
package loopdiv_pkg;
  localparam int CODE_W    = 14;
  localparam int AM_RATIO  = 8;
  localparam int FM_LOW    = 63;
  localparam int SWALLOW_W = 6;
endpackage

// File: rtl/lpd_fixed_prescale.sv
module lpd_fixed_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign pulse_o = tick_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)       cnt_d = '0;
    else if (pulse_o)  cnt_d = '0;
    else if (tick_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpd_dual_prescale.sv
module lpd_dual_prescale #(
  parameter int P = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  input  logic high_mod_i,
  output logic pulse_o
);
  localparam int W = $clog2(P + 1);
  localparam logic [W-1:0] LAST_HI = W'(P);
  localparam logic [W-1:0] LAST_LO = W'(P - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] last;

  assign last    = high_mod_i ? LAST_HI : LAST_LO;
  assign pulse_o = tick_i && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)       cnt_d = '0;
    else if (pulse_o)  cnt_d = '0;
    else if (tick_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpd_main_counter.sv
module lpd_main_counter #(
  parameter int CODE_W    = 14,
  parameter int SWALLOW_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              pre_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              terminal_o,
  output logic              high_mod_o,
  output logic [CODE_W-1:0] cnt_o
);
  logic [CODE_W-1:0]    cnt_q, cnt_d;
  logic [SWALLOW_W-1:0] sw_q, sw_d;
  logic                 at_zero;

  assign at_zero    = (cnt_q == '0);
  assign terminal_o = pre_i && at_zero;
  assign high_mod_o = (sw_q != '0);
  assign cnt_o      = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    sw_d  = sw_q;
    if (clear_i) begin
      cnt_d = '0;
      sw_d  = '0;
    end else if (pre_i) begin
      if (at_zero) begin
        cnt_d = code_i;
        sw_d  = code_i[SWALLOW_W-1:0];
      end else begin
        cnt_d = cnt_q - 1'b1;
        if (high_mod_o) sw_d = sw_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sw_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sw_q  <= sw_d;
    end
  end
endmodule

// File: rtl/loop_divider.sv
module loop_divider
  import loopdiv_pkg::*;
#(
  parameter int N_BITS   = CODE_W,
  parameter int AM_DIV   = AM_RATIO,
  parameter int FM_P     = FM_LOW,
  parameter int SW_BITS  = SWALLOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              am_tick,
  input  logic              fm_tick,
  input  logic              fm_sel,
  input  logic [N_BITS-1:0] div_code,
  output logic              div_pulse
);
  logic              rst_meta, rst_s;
  logic              sel_q;
  logic              sel_clear;
  logic              am_en, fm_en;
  logic              am_pre, fm_pre, pre_pulse;
  logic              terminal, high_mod;
  logic [N_BITS-1:0] main_cnt;
  logic              out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign sel_clear = (fm_sel != sel_q);
  assign am_en     = am_tick && !fm_sel && !sel_clear;
  assign fm_en     = fm_tick &&  fm_sel && !sel_clear;

  lpd_fixed_prescale #(.DIV(AM_DIV)) u_am (
    .clk(clk), .rst_n(rst_s), .clear_i(sel_clear),
    .tick_i(am_en), .pulse_o(am_pre)
  );

  lpd_dual_prescale #(.P(FM_P)) u_fm (
    .clk(clk), .rst_n(rst_s), .clear_i(sel_clear),
    .tick_i(fm_en), .high_mod_i(high_mod), .pulse_o(fm_pre)
  );

  assign pre_pulse = sel_q ? fm_pre : am_pre;

  lpd_main_counter #(.CODE_W(N_BITS), .SWALLOW_W(SW_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_s), .clear_i(sel_clear), .pre_i(pre_pulse),
    .code_i(div_code), .terminal_o(terminal), .high_mod_o(high_mod),
    .cnt_o(main_cnt)
  );

  assign out_d = terminal && !sel_clear;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_q     <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      sel_q     <= fm_sel;
      div_pulse <= out_d;
    end
  end
endmodule

// File: rtl/loop_divider_chk.sv
module loop_divider_chk #(
  parameter int N_BITS = 14
) (
  input logic              clk,
  input logic              rst_s,
  input logic              am_tick,
  input logic              fm_tick,
  input logic              fm_sel,
  input logic              sel_clear,
  input logic              pre_pulse,
  input logic [N_BITS-1:0] main_cnt,
  input logic              div_pulse
);
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_s)
    div_pulse |-> $past(fm_sel ? fm_tick : am_tick)); // R8

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_s)
    div_pulse |=> !div_pulse); // R8

  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_s)
    sel_clear |=> !div_pulse); // R6

  AST_COUNT_ON_PRESCALE: assert property (@(posedge clk) disable iff (!rst_s)
    (main_cnt != $past(main_cnt)) |-> ($past(pre_pulse) || $past(sel_clear))); // R5
endmodule

bind loop_divider loop_divider_chk #(.N_BITS(N_BITS)) u_chk (
  .clk(clk), .rst_s(rst_s), .am_tick(am_tick), .fm_tick(fm_tick),
  .fm_sel(fm_sel), .sel_clear(sel_clear), .pre_pulse(pre_pulse),
  .main_cnt(main_cnt), .div_pulse(div_pulse)
);

// File: tb/tb_loop_divider.sv
module tb_loop_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int WATCHDOG = 180000;

  localparam int    VSEL [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int    VCODE[NV] = '{0, 4, 9, 0, 2, 65, 64, 7, 63, 1, 8192};
  localparam int    VEXP [NV] = '{8, 40, 80, 63, 191, 4159, 4095, 511, 4095, 127, 65544};
  localparam string VTAG [NV] = '{"R3", "R1", "R1", "R3", "R2", "R2", "R2", "R2", "R2", "R2", "R9"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        am_tick, fm_tick, fm_sel;
  logic [13:0] div_code;
  logic        div_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_divider dut (
    .clk(clk), .rst_n(rst_n), .am_tick(am_tick), .fm_tick(fm_tick),
    .fm_sel(fm_sel), .div_code(div_code), .div_pulse(div_pulse)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic do_reset(input logic sel, input int code);
    rst_n = 1'b0; am_tick = 1'b0; fm_tick = 1'b0;
    fm_sel = sel; div_code = 14'(code);
    repeat (3) @(negedge clk);
    check("R7 held", int'(div_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // counts ticks until a pulse; gap=1 drives a tick every other cycle
  task automatic wait_pulse(input bit gap, output int n);
    bit phase = 1'b0;
    n = 0;
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      if (div_pulse) begin
        am_tick = 1'b0; fm_tick = 1'b0;
        return;
      end
      phase = gap ? ~phase : 1'b1;
      am_tick = phase; fm_tick = phase;
      if (phase) n++;
    end
    n = -1;
  endtask

  task automatic run_ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      am_tick = 1'b1; fm_tick = 1'b1;
    end
    @(negedge clk);
    am_tick = 1'b0; fm_tick = 1'b0;
  endtask

  initial begin
    int n;
    int quiet;
    do_reset(1'b0, 0);
    check("R7 idle", int'(div_pulse), 0);

    for (int v = 0; v < NV; v++) begin
      do_reset(VSEL[v] != 0, VCODE[v]);
      wait_pulse(1'b0, n);
      check({VTAG[v], " first"}, n, (VSEL[v] != 0) ? 63 : 8);
      wait_pulse(1'b0, n);
      check(VTAG[v], n, VEXP[v]);
      @(negedge clk);
      check("R8 width", int'(div_pulse), 0);
    end

    // R5: code change in the middle of a cycle
    do_reset(1'b0, 9);
    wait_pulse(1'b0, n);
    run_ticks(20);
    div_code = 14'd2;
    wait_pulse(1'b0, n);
    check("R5 current", 20 + n, 80);
    wait_pulse(1'b0, n);
    check("R5 next", n, 24);

    // R6: switch to FM part way through an AM cycle
    run_ticks(5);
    fm_sel = 1'b1;
    @(negedge clk);
    wait_pulse(1'b0, n);
    check("R6 first", n, 63);
    wait_pulse(1'b0, n);
    check("R6 full", n, 191);

    // R4: only AM ticks while FM is selected
    quiet = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (div_pulse) quiet++;
      am_tick = 1'b1; fm_tick = 1'b0;
    end
    am_tick = 1'b0;
    check("R4 unselected", quiet, 0);

    // R1: gapped ticks are counted as ticks
    do_reset(1'b0, 1);
    wait_pulse(1'b1, n);
    wait_pulse(1'b1, n);
    check("R1 gapped", n, 16);

    finish_run();
  end
endmodule